// File: doc/BRIEF.md
# Aligned Transfer Segment Splitter

This block accepts one transfer request, given as a start address and a byte length. It turns the request into a stream of (address, length) segments. Each segment fits the largest size a single buffer slot can take, 0x1FFF bytes. Each segment also keeps 4-byte address alignment.

A request longer than the slot limit is not cut into full-size pieces followed by a small leftover. The block first works out how many 4-byte-trimmed pieces of at most 0x1FFC bytes are needed. It then makes every piece close to the same size, so no tiny trailing segment remains. Both divisions run on one shared multi-cycle restoring divider.

Requests enter through a valid/ready handshake. Segments leave through a valid/ready stream. Completion is flagged by a `done` pulse, and a refused request is flagged by an `err` pulse.

Top module: `seg_splitter`

## Requirements
- R1: After reset, `req_ready` is 1, and `seg_valid`, `done` and `err` are 0.
- R2: A request is refused when bits [1:0] of its address are not both zero, or when its length is zero. The refusal is an `err` pulse of one cycle in the cycle after acceptance. The request produces no segment and no `done`, and `req_ready` stays 1.
- R3: A remaining length of at most 0x1FFF is emitted as one segment carrying the whole remainder.
- R4: A remaining length R above 0x1FFF gives a segment of length floor(R / N) with bits [1:0] forced to zero, where N = ceil(R / 0x1FFC).
- R5: The first segment starts at the request address. Each later segment starts at the previous address plus the previous length. The remaining length shrinks by each emitted length until it is zero, so the lengths add up to the request length.
- R6: Every emitted segment has a length from 1 to 0x1FFF and an address with bits [1:0] equal to zero.
- R7: While `seg_valid` is 1 and `seg_ready` is 0, the segment stays valid and its address and length do not change.
- R8: `done` is 1 exactly in the cycle the final segment is accepted, and at no other time. `done` and `err` are never 1 together.
- R9: `req_ready` is 0 from the cycle after a request is accepted until the cycle after its final segment is accepted. This covers the whole time the divider is busy.
- R10: The divider's quotient and remainder reproduce its dividend exactly, and it never starts with a zero divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Request start address |
| req_len | input | LEN_W | Request length in bytes |
| seg_valid | output | 1 | Segment available |
| seg_ready | input | 1 | Consumer takes the segment |
| seg_addr | output | ADDR_W | Segment start address |
| seg_len | output | LEN_W | Segment length in bytes |
| done | output | 1 | Final segment accepted this cycle |
| err | output | 1 | Previous request refused |

## Verification
The bench uses directed lengths at and around the slot limit: 1, 2, 0x1FFF, 0x2000, 0x3FF9, and the largest value that fits in `req_len`. These separate the single-segment path from the two-way and three-way equal splits, and they expose any off-by-one in the ceiling count or the alignment trim.

Lengths and aligned addresses drawn at random are run with `seg_ready` both held high and randomly dropped. These runs test address accumulation, stability of a held segment, and `done` timing on long chains of segments.

Misaligned addresses and zero lengths confirm that a refusal gives only an `err` pulse, with no segment and no `done`.

// File: rtl/seg_pkg.sv
package seg_pkg;

    localparam int          DEF_ADDR_W     = 32;
    localparam int          DEF_LEN_W      = 16;
    localparam int          DEF_ALIGN_BITS = 2;
    localparam logic [31:0] DEF_MAX_SEG    = 32'h0000_1FFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLAN,
        ST_COUNT,
        ST_SIZE,
        ST_EMIT
    } split_state_e;

    function automatic logic [31:0] align_down(input logic [31:0] v, input int unsigned bits);
        logic [31:0] mask;
        mask = (32'd1 << bits) - 32'd1;
        return v & ~mask;
    endfunction

endpackage

// File: rtl/seg_req_check.sv
module seg_req_check #(
    parameter int ALIGN_BITS = 2,
    parameter int LEN_W      = 16
) (
    input  logic [ALIGN_BITS-1:0] addr_lsb,
    input  logic [LEN_W-1:0]      len,
    output logic                  reject
);
    logic misaligned;
    logic empty;

    always_comb begin
        misaligned = |addr_lsb;
        empty      = (len == '0);
        reject     = misaligned | empty;
    end
endmodule

// File: rtl/seg_divider.sv
module seg_divider #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient
);
    localparam int CW = $clog2(W + 1);
    localparam int W2 = 2 * W;

    logic [W-1:0]  acc_q, quo_q, dsr_q, dvd_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q, done_q;
    logic [W:0]    shifted, diff;
    logic [W2-1:0] rebuilt;

    always_comb begin
        shifted = {acc_q, quo_q[W-1]};
        diff    = shifted - {1'b0, dsr_q};
        rebuilt = W2'(quo_q) * W2'(dsr_q) + W2'(acc_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            quo_q  <= '0;
            dsr_q  <= '0;
            dvd_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && !busy_q) begin
                acc_q  <= '0;
                quo_q  <= dividend;
                dsr_q  <= divisor;
                dvd_q  <= dividend;
                cnt_q  <= CW'(W - 1);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                if (!diff[W]) begin
                    acc_q <= diff[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    acc_q <= shifted[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                if (cnt_q == '0) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign busy     = busy_q;
    assign done     = done_q;
    assign quotient = quo_q;

    AST_DIV_EXACT: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (rebuilt == W2'(dvd_q) && acc_q < dsr_q)); // R10
    AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (start && !busy_q) |-> (divisor != '0)); // R10
    AST_DIV_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> !start); // R10
endmodule

// File: rtl/seg_splitter.sv
module seg_splitter
    import seg_pkg::*;
#(
    parameter int          ADDR_W     = DEF_ADDR_W,
    parameter int          LEN_W      = DEF_LEN_W,
    parameter int          ALIGN_BITS = DEF_ALIGN_BITS,
    parameter logic [31:0] MAX_SEG    = DEF_MAX_SEG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              seg_valid,
    input  logic              seg_ready,
    output logic [ADDR_W-1:0] seg_addr,
    output logic [LEN_W-1:0]  seg_len,
    output logic              done,
    output logic              err
);
    localparam int              DIV_W  = LEN_W + 1;
    localparam logic [31:0]     STEP32 = align_down(MAX_SEG, ALIGN_BITS);
    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_SEG);
    localparam logic [DIV_W-1:0] STEP_D = DIV_W'(STEP32);
    localparam logic [DIV_W-1:0] ROUND_D = DIV_W'(STEP32 - 32'd1);

    split_state_e      state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q, len_q;
    logic              err_q;
    logic              reject;
    logic              accept, last;

    logic              div_start, div_busy, div_done;
    logic [DIV_W-1:0]  div_dvd, div_dsr, div_quo;

    seg_req_check #(.ALIGN_BITS(ALIGN_BITS), .LEN_W(LEN_W)) u_check (
        .addr_lsb (req_addr[ALIGN_BITS-1:0]),
        .len      (req_len),
        .reject   (reject)
    );

    seg_divider #(.W(DIV_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_start),
        .dividend (div_dvd),
        .divisor  (div_dsr),
        .busy     (div_busy),
        .done     (div_done),
        .quotient (div_quo)
    );

    // Divider operand selection: piece count first, then the piece size.
    always_comb begin
        div_start = 1'b0;
        div_dvd   = '0;
        div_dsr   = '0;
        case (state_q)
            ST_PLAN: begin
                if (rem_q > MAX_L) begin
                    div_start = 1'b1;
                    div_dvd   = DIV_W'(rem_q) + ROUND_D;
                    div_dsr   = STEP_D;
                end
            end
            ST_COUNT: begin
                if (div_done) begin
                    div_start = 1'b1;
                    div_dvd   = DIV_W'(rem_q);
                    div_dsr   = div_quo;
                end
            end
            default: ;
        endcase
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        seg_valid = (state_q == ST_EMIT);
        seg_addr  = addr_q;
        seg_len   = len_q;
        accept    = req_valid && req_ready;
        last      = (rem_q == len_q);
        done      = seg_valid && seg_ready && last;
        err       = err_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            rem_q   <= '0;
            len_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (reject) begin
                            err_q <= 1'b1;
                        end else begin
                            addr_q  <= req_addr;
                            rem_q   <= req_len;
                            state_q <= ST_PLAN;
                        end
                    end
                end
                ST_PLAN: begin
                    if (rem_q <= MAX_L) begin
                        len_q   <= rem_q;
                        state_q <= ST_EMIT;
                    end else begin
                        state_q <= ST_COUNT;
                    end
                end
                ST_COUNT: begin
                    if (div_done) state_q <= ST_SIZE;
                end
                ST_SIZE: begin
                    if (div_done) begin
                        len_q   <= LEN_W'(align_down(32'(div_quo), ALIGN_BITS));
                        state_q <= ST_EMIT;
                    end
                end
                ST_EMIT: begin
                    if (seg_ready) begin
                        addr_q  <= addr_q + ADDR_W'(len_q);
                        rem_q   <= rem_q - len_q;
                        state_q <= last ? ST_IDLE : ST_PLAN;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_SEG_BOUND: assert property (@(posedge clk) disable iff (rst)
        seg_valid |-> (seg_len != '0 && seg_len <= MAX_L)); // R6
    AST_SEG_ALIGN: assert property (@(posedge clk) disable iff (rst)
        seg_valid |-> (seg_addr[ALIGN_BITS-1:0] == '0)); // R6
    AST_SEG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr) && $stable(seg_len))); // R7
    AST_SEG_FITS_REM: assert property (@(posedge clk) disable iff (rst)
        seg_valid |-> (seg_len <= rem_q)); // R5
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        div_busy |-> !req_ready); // R9
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && err)); // R8
    AST_ERR_NO_SEG: assert property (@(posedge clk) disable iff (rst)
        err |-> (!seg_valid && req_ready)); // R2
endmodule

// File: tb/seg_splitter_test.sv
module seg_splitter_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAXL = 32'h1FFF;
    localparam int STEP = 32'h1FFC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic        seg_valid;
    logic        seg_ready = 1'b0;
    logic [31:0] seg_addr;
    logic [15:0] seg_len;
    logic        done;
    logic        err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    seg_splitter uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len),
        .seg_valid(seg_valid), .seg_ready(seg_ready),
        .seg_addr(seg_addr), .seg_len(seg_len),
        .done(done), .err(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected below 190000", cycles);
            report();
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int model_len(input int rem);
        int n;
        if (rem <= MAXL) return rem;
        n = (rem + STEP - 1) / STEP;
        return (rem / n) & ~3;
    endfunction

    function automatic int model_count(input int total);
        int k = 0;
        int r = total;
        while (r > 0) begin
            r = r - model_len(r);
            k++;
        end
        return k;
    endfunction

    task automatic run_req(input logic [31:0] a, input int l, input bit bp);
        logic [31:0] exp_addr = a;
        int rem = l;
        int nseg = 0;
        int n = 0;
        bit pend = 0;
        logic [31:0] held_addr = '0;
        logic [15:0] held_len = '0;
        int el;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_len = l[15:0];
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R9 ready low after accept", req_ready, 0);
        while (rem > 0 && n < 6000) begin
            seg_ready = bp ? (($urandom % 3) != 0) : 1'b1;
            #1;
            if (seg_valid) begin
                if (pend) begin
                    chk(seg_addr == held_addr && seg_len == held_len,
                        "R7 held segment", {seg_addr, seg_len}, {held_addr, held_len});
                end
                el = model_len(rem);
                chk(seg_addr == exp_addr, "R5 segment address", seg_addr, exp_addr);
                chk(int'(seg_len) == el, rem <= MAXL ? "R3 single length" : "R4 split length",
                    seg_len, el);
                chk(seg_len != 0 && int'(seg_len) <= MAXL && seg_addr[1:0] == 2'b00,
                    "R6 bounds", {seg_addr, seg_len}, el);
                if (seg_ready) begin
                    chk(done == (rem == el), "R8 done timing", done, rem == el);
                    exp_addr = exp_addr + el;
                    rem = rem - el;
                    nseg++;
                    pend = 0;
                end else begin
                    chk(done == 1'b0, "R8 done while stalled", done, 0);
                    pend = 1; held_addr = seg_addr; held_len = seg_len;
                end
            end else begin
                chk(done == 1'b0 && req_ready == 1'b0, "R9 busy between segments",
                    {done, req_ready}, 0);
            end
            @(negedge clk);
            n++;
        end
        seg_ready = 1'b0;
        chk(nseg == model_count(l), "R5 segment count", nseg, model_count(l));
        chk(req_ready == 1'b1 && seg_valid == 1'b0 && done == 1'b0,
            "R9 idle after final", {req_ready, seg_valid, done}, 3'b100);
    endtask

    task automatic run_bad(input logic [31:0] a, input int l);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_len = l[15:0];
        @(negedge clk);
        req_valid = 1'b0;
        chk(err == 1'b1, "R2 err pulse", err, 1);
        chk(seg_valid == 1'b0 && done == 1'b0 && req_ready == 1'b1,
            "R2 no segment", {seg_valid, done, req_ready}, 3'b001);
        @(negedge clk);
        chk(err == 1'b0, "R2 err one cycle", err, 0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (seg_valid || done) chk(1'b0, "R2 late segment", {seg_valid, done}, 0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(req_ready == 1'b1 && seg_valid == 1'b0 && done == 1'b0 && err == 1'b0,
            "R1 reset state", {req_ready, seg_valid, done, err}, 4'b1000);

        run_req(32'h0000_1000, 1, 0);
        run_req(32'h0000_2000, 2, 1);
        run_req(32'h0000_2000, 32'h1FFF, 0);
        run_req(32'h0000_0004, 32'h2000, 0);
        run_req(32'h0000_0100, 32'h3FF9, 1);
        run_req(32'h0000_0000, 32'hFFFF, 1);
        run_req(32'hFFFF_F000, 32'h9000, 0);

        run_bad(32'h0000_1001, 100);
        run_bad(32'h0000_2000, 0);
        run_bad(32'h0000_0003, 0);
        run_bad(32'h0000_0002, 32'h4000);

        for (int t = 0; t < 40; t++) begin
            logic [31:0] a;
            int l;
            a = $urandom() & 32'hFFFF_FFFC;
            l = (t % 4 == 0) ? int'($urandom_range(1, 32'h1FFF)) : int'($urandom_range(1, 32'hFFFF));
            run_req(a, l, t[0]);
        end
        run_bad(32'h0000_4003, 16);

        report();
    end
endmodule